// File: doc/BRIEF.md
# Half-Duplex Transmit Deferral and Collision Retry Controller

This block decides the moment a queued frame may go onto a shared, half-duplex Ethernet segment, and it recovers from collisions. When a frame is waiting, the controller first watches carrier sense until the line has been quiet for 60 bit times. A carrier burst in that window starts the count again. A further 36 bit times then pass without regard to carrier. After that, a one-cycle start pulse goes to the frame formatter. All timing advances only on a bit-time tick supplied from outside. At 10 Mb/s the tick is 100 ns, so the two stages take 6.0 µs and 3.6 µs.

If a collision is reported while the frame is on the wire, the controller pulses abort and keeps transmit-enable asserted for a 32-bit-time jam. It then counts the collision. While the count is within the programmed retry limit, it pulses a rewind request so the formatter restarts from the frame's first buffer. It waits a random truncated binary exponential backoff, measured in slot times, and then runs the full deferral again. Once the count goes past the limit, the frame is dropped: done and a sticky retry-failure flag rise together. A small head store keeps the first bytes sent on the first attempt, so a retry can replay them without fetching them again. Because of this, the formatter must place at least nine bytes in a frame's first buffer.

Top module: `mac_defer_retry`

## Requirements
- R1: With carrier inactive, a frame seen pending in idle gets a one-cycle `tx_start` after exactly 60 + 36 = 96 bit ticks. When carrier is active at that point, `tx_start` comes 96 ticks after the first tick on which carrier reads low.
- R2: Carrier high on any cycle of the first (60-tick) stage clears its count, so the 96-tick wait is measured again from the next cycle with carrier low.
- R3: Carrier during the second (36-tick) stage has no effect on the time of `tx_start`.
- R4: Deferral, jam and backoff counters advance only on cycles with `bit_tick` high. Without ticks, no `tx_start` occurs.
- R5: A collision while transmitting produces a one-cycle `tx_abort` in the next cycle. `jam_on` and `tx_en` then stay high for exactly 32 ticks before both drop.
- R6: After the jam, if the collision count n is not above `retry_limit`, `rewind` pulses for one cycle with `tx_en` low. The next `tx_start` follows k·SLOT_TICKS + 1 + 96 ticks later, where 0 ≤ k ≤ 2^min(n,10) − 1 is taken from a free-running LFSR.
- R7: When the collision count exceeds `retry_limit`, `done` and `retry_fail` rise in the same cycle and `rewind` does not pulse. `retry_fail` holds until the next frame is accepted.
- R8: `tx_last` during transmission with no collision gives a one-cycle `done`, drops `tx_en`, and leaves `retry_fail` low.
- R9: When `col` and `tx_last` arrive in the same transmitting cycle, the collision wins: `tx_abort` pulses, the jam starts, and no `done` is given in that cycle.
- R10: The head store keeps the first HEAD_BYTES (8) bytes strobed by `tx_byte_vld` during the first attempt only. `rp_data` returns byte `rp_idx`, and `rp_cnt` gives the stored count, saturating at 8. Bytes sent on retries do not overwrite the store. Accepting a new frame clears `rp_cnt` to 0.
- R11: `col` outside transmission (idle, deferral, backoff) is ignored: no `tx_abort`, and the start timing is unchanged.
- R12: After reset, `tx_start`, `tx_en`, `jam_on`, `tx_abort`, `rewind`, `done` and `retry_fail` are 0, and `rp_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| frame_pending | input | 1 | A frame is queued for sending |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision detect |
| tx_last | input | 1 | Formatter has sent the last bit of the frame |
| retry_limit | input | RETRY_W | Highest collision count that still allows a retry |
| tx_byte_vld | input | 1 | Strobe for a byte going out |
| tx_byte | input | 8 | Byte going out |
| rp_idx | input | $clog2(HEAD_BYTES) | Head store read index |
| tx_start | output | 1 | One-cycle start pulse to formatter |
| tx_en | output | 1 | Transmit enable (frame or jam) |
| jam_on | output | 1 | Jam pattern being sent |
| tx_abort | output | 1 | One-cycle frame abort on collision |
| rewind | output | 1 | One-cycle request to restart from first buffer |
| done | output | 1 | One-cycle frame completion (sent or dropped) |
| retry_fail | output | 1 | Frame dropped after too many collisions |
| rp_data | output | 8 | Head store byte at `rp_idx` |
| rp_cnt | output | $clog2(HEAD_BYTES+1) | Number of bytes held in the head store |

## Verification
Collision detect and end of frame can both fall in the same transmitting cycle. The bench provokes this by raising `col` and `tx_last` on one clock, then requires an abort and a jam with no completion in that cycle. A properly ordered completion, together with the retry failure, must follow only after the jam. A second pairing lands a collision pulse during the deferral that follows a backoff: the measured start delay must still fit the slot-multiple formula, and no abort may appear.

// File: rtl/dfr_pkg.sv
// Package: shared state types for the deferral/retry controller.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package dfr_pkg;

    // Main controller states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEFER,
        ST_TX,
        ST_JAM,
        ST_BACKOFF
    } tx_state_e;

    // Deferral timer phases.
    typedef enum logic [1:0] {
        DP_OFF,
        DP_QUIET,
        DP_GAP
    } defer_phase_e;

endpackage

// File: rtl/dfr_defer_timer.sv
// Module: two-stage interframe deferral timer.
// After arm, counts QUIET_TICKS ticks of continuous carrier absence (carrier
// restarts the count), then GAP_TICKS further ticks ignoring carrier, and
// raises fire combinationally on the last tick of the gap.
// Assumes: arm is a single-cycle request; QUIET_TICKS and GAP_TICKS >= 1.
module dfr_defer_timer
    import dfr_pkg::*;
#(
    parameter int QUIET_TICKS = 60,
    parameter int GAP_TICKS   = 36
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic crs,
    input  logic arm,
    output logic fire,
    output logic in_gap
);
    localparam int MAXT = (QUIET_TICKS > GAP_TICKS) ? QUIET_TICKS : GAP_TICKS;
    localparam int CW   = $clog2(MAXT + 1);

    defer_phase_e    phase;
    logic [CW-1:0]   cnt;

    assign fire   = (phase == DP_GAP) && tick && (cnt == CW'(GAP_TICKS - 1));
    assign in_gap = (phase == DP_GAP);

    // Phase and count sequencing for the two deferral stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= DP_OFF;
            cnt   <= '0;
        end else if (arm) begin
            phase <= DP_QUIET;
            cnt   <= '0;
        end else begin
            case (phase)
                DP_QUIET: begin
                    if (crs) begin
                        cnt <= '0;
                    end else if (tick) begin
                        if (cnt == CW'(QUIET_TICKS - 1)) begin
                            phase <= DP_GAP;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                DP_GAP: begin
                    if (tick) begin
                        if (cnt == CW'(GAP_TICKS - 1)) begin
                            phase <= DP_OFF;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    phase <= DP_OFF;
                    cnt   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/dfr_backoff.sv
// Module: truncated binary exponential backoff delay.
// On load, picks k = LFSR & (2^min(n,CAP)-1) slots and counts k*SLOT_TICKS
// ticks; expire is high for one cycle once the slot count is exhausted.
// Assumes: SLOT_TICKS >= 2, CAP <= 16, SEED nonzero.
module dfr_backoff #(
    parameter int          SLOT_TICKS = 512,
    parameter int          CAP        = 10,
    parameter int          NCOL_W     = 5,
    parameter logic [15:0] SEED       = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [NCOL_W-1:0] coll_n,
    output logic              expire
);
    localparam int SC_W = $clog2(SLOT_TICKS);

    logic [15:0]     lfsr;
    logic [CAP-1:0]  mask;
    logic [CAP-1:0]  slots;
    logic [SC_W-1:0] sc;
    logic            active;

    // Free-running maximal-length LFSR as the random source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr <= SEED;
        end else begin
            lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
    end

    // Range mask: bit i set while i is below the collision count (caps at CAP).
    always_comb begin
        for (int i = 0; i < CAP; i++) begin
            mask[i] = (i < int'(coll_n));
        end
    end

    assign expire = active && (slots == '0);

    // Slot countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            slots  <= '0;
            sc     <= '0;
        end else if (load) begin
            active <= 1'b1;
            slots  <= lfsr[CAP-1:0] & mask;
            sc     <= '0;
        end else if (active) begin
            if (slots == '0) begin
                active <= 1'b0;
            end else if (tick) begin
                if (sc == SC_W'(SLOT_TICKS - 1)) begin
                    sc    <= '0;
                    slots <= slots - 1'b1;
                end else begin
                    sc <= sc + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dfr_head_store.sv
// Module: replay store for the leading bytes of a frame.
// Captures up to DEPTH bytes while cap_en is high, then holds them for
// replay on retries; clr empties it for a new frame. Read is combinational.
// Assumes: DEPTH is a power of two.
module dfr_head_store #(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cap_en,
    input  logic             wr_vld,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic [CNT_W-1:0] fill
);
    logic [7:0] mem [DEPTH];
    logic       wr_ok;

    assign wr_ok   = cap_en && wr_vld && (fill < CNT_W'(DEPTH));
    assign rd_data = mem[rd_idx];

    // Fill level tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill <= '0;
        end else if (clr) begin
            fill <= '0;
        end else if (wr_ok) begin
            fill <= fill + 1'b1;
        end
    end

    // Byte storage (no reset needed; fill qualifies contents).
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[fill[IDX_W-1:0]] <= wr_data;
        end
    end
endmodule

// File: rtl/mac_defer_retry.sv
// Module: top of the half-duplex deferral and collision retry controller.
// Sequences idle -> deferral -> transmit, and on collision -> jam -> backoff
// -> deferral, or drops the frame when the retry limit is passed.
// Assumes: the formatter holds tx_last for one cycle at frame end and keeps
// at least nine bytes in the first buffer; bit_tick is one cycle wide.
module mac_defer_retry
    import dfr_pkg::*;
#(
    parameter int          IFG1_TICKS  = 60,
    parameter int          IFG2_TICKS  = 36,
    parameter int          JAM_TICKS   = 32,
    parameter int          SLOT_TICKS  = 512,
    parameter int          BACKOFF_CAP = 10,
    parameter int          RETRY_W     = 4,
    parameter int          HEAD_BYTES  = 8,
    parameter logic [15:0] LFSR_SEED   = 16'hACE1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bit_tick,
    input  logic                            frame_pending,
    input  logic                            crs,
    input  logic                            col,
    input  logic                            tx_last,
    input  logic [RETRY_W-1:0]              retry_limit,
    input  logic                            tx_byte_vld,
    input  logic [7:0]                      tx_byte,
    input  logic [$clog2(HEAD_BYTES)-1:0]   rp_idx,
    output logic                            tx_start,
    output logic                            tx_en,
    output logic                            jam_on,
    output logic                            tx_abort,
    output logic                            rewind,
    output logic                            done,
    output logic                            retry_fail,
    output logic [7:0]                      rp_data,
    output logic [$clog2(HEAD_BYTES+1)-1:0] rp_cnt
);
    localparam int NCOL_W = RETRY_W + 1;
    localparam int JAM_W  = $clog2(JAM_TICKS);
    localparam int IDX_W  = $clog2(HEAD_BYTES);
    localparam int CNT_W  = $clog2(HEAD_BYTES + 1);

    tx_state_e         state;
    logic [NCOL_W-1:0] ncol;
    logic [NCOL_W-1:0] ncol_nx;
    logic [JAM_W-1:0]  jcnt;
    logic              accept;
    logic              jam_end;
    logic              give_up;
    logic              arm;
    logic              defer_fire;
    logic              dfr_in_gap;
    logic              bo_load;
    logic              bo_expire;
    logic              cap_en;

    assign accept  = (state == ST_IDLE) && frame_pending;
    assign jam_end = (state == ST_JAM) && bit_tick && (jcnt == JAM_W'(JAM_TICKS - 1));
    assign ncol_nx = ncol + 1'b1;
    assign give_up = ncol_nx > {1'b0, retry_limit};
    assign bo_load = jam_end && !give_up;
    assign arm     = accept || ((state == ST_BACKOFF) && bo_expire);
    assign cap_en  = (state == ST_TX) && (ncol == '0);
    assign tx_en   = (state == ST_TX) || (state == ST_JAM);
    assign jam_on  = (state == ST_JAM);

    dfr_defer_timer #(
        .QUIET_TICKS (IFG1_TICKS),
        .GAP_TICKS   (IFG2_TICKS)
    ) defer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (bit_tick),
        .crs    (crs),
        .arm    (arm),
        .fire   (defer_fire),
        .in_gap (dfr_in_gap)
    );

    dfr_backoff #(
        .SLOT_TICKS (SLOT_TICKS),
        .CAP        (BACKOFF_CAP),
        .NCOL_W     (NCOL_W),
        .SEED       (LFSR_SEED)
    ) backoff_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (bit_tick),
        .load   (bo_load),
        .coll_n (ncol_nx),
        .expire (bo_expire)
    );

    dfr_head_store #(
        .DEPTH (HEAD_BYTES),
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) head_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .cap_en  (cap_en),
        .wr_vld  (tx_byte_vld),
        .wr_data (tx_byte),
        .rd_idx  (rp_idx),
        .rd_data (rp_data),
        .fill    (rp_cnt)
    );

    // Controller state machine with registered one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            ncol       <= '0;
            jcnt       <= '0;
            tx_start   <= 1'b0;
            tx_abort   <= 1'b0;
            rewind     <= 1'b0;
            done       <= 1'b0;
            retry_fail <= 1'b0;
        end else begin
            tx_start <= 1'b0;
            tx_abort <= 1'b0;
            rewind   <= 1'b0;
            done     <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (frame_pending) begin
                        state      <= ST_DEFER;
                        ncol       <= '0;
                        retry_fail <= 1'b0;
                    end
                end
                ST_DEFER: begin
                    if (defer_fire) begin
                        state    <= ST_TX;
                        tx_start <= 1'b1;
                    end
                end
                ST_TX: begin
                    if (col) begin
                        state    <= ST_JAM;
                        jcnt     <= '0;
                        tx_abort <= 1'b1;
                    end else if (tx_last) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                ST_JAM: begin
                    if (jam_end) begin
                        ncol <= ncol_nx;
                        if (give_up) begin
                            state      <= ST_IDLE;
                            done       <= 1'b1;
                            retry_fail <= 1'b1;
                        end else begin
                            state  <= ST_BACKOFF;
                            rewind <= 1'b1;
                        end
                    end else if (bit_tick) begin
                        jcnt <= jcnt + 1'b1;
                    end
                end
                ST_BACKOFF: begin
                    if (bo_expire) begin
                        state <= ST_DEFER;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dfr_checker.sv
// Module: property checker for mac_defer_retry, attached by bind.
// Assumes: connected to the top's ports plus its gap-stage indicator.
module dfr_checker (
    input logic clk,
    input logic rst_n,
    input logic crs,
    input logic col,
    input logic tx_last,
    input logic tx_start,
    input logic tx_en,
    input logic jam_on,
    input logic tx_abort,
    input logic rewind,
    input logic done,
    input logic retry_fail,
    input logic in_gap
);
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start); // R1

    AST_START_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(in_gap)); // R1

    AST_GAP_IGNORES_CRS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_gap && crs) |=> (in_gap || tx_start)); // R3

    AST_COL_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !jam_on && col) |=> (tx_abort && jam_on)); // R5

    AST_JAM_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        jam_on |-> tx_en); // R5

    AST_REWIND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |-> (!done && !tx_en)); // R6

    AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(retry_fail) |-> (done && !rewind)); // R7

    AST_CLEAN_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !jam_on && !col && tx_last) |=> (done && !tx_en && !retry_fail)); // R8

    AST_COL_BEATS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !jam_on && col && tx_last) |=> !done); // R9

    AST_IDLE_COL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && col) |=> !tx_abort); // R11
endmodule

bind mac_defer_retry dfr_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .crs        (crs),
    .col        (col),
    .tx_last    (tx_last),
    .tx_start   (tx_start),
    .tx_en      (tx_en),
    .jam_on     (jam_on),
    .tx_abort   (tx_abort),
    .rewind     (rewind),
    .done       (done),
    .retry_fail (retry_fail),
    .in_gap     (dfr_in_gap)
);

// File: tb/mac_defer_retry_tb_top.sv
// Directed bench for mac_defer_retry; each task drives and checks a scenario.
module mac_defer_retry_tb_top;
    localparam int SLOT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b1;
    logic       frame_pending = 1'b0;
    logic       crs = 1'b0;
    logic       col = 1'b0;
    logic       tx_last = 1'b0;
    logic [3:0] retry_limit = 4'd3;
    logic       tx_byte_vld = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic [2:0] rp_idx = 3'd0;
    logic       tx_start, tx_en, jam_on, tx_abort, rewind, done, retry_fail;
    logic [7:0] rp_data;
    logic [3:0] rp_cnt;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    mac_defer_retry #(.SLOT_TICKS(SLOT)) dut_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_pending(frame_pending),
        .crs(crs), .col(col), .tx_last(tx_last), .retry_limit(retry_limit),
        .tx_byte_vld(tx_byte_vld), .tx_byte(tx_byte), .rp_idx(rp_idx),
        .tx_start(tx_start), .tx_en(tx_en), .jam_on(jam_on), .tx_abort(tx_abort),
        .rewind(rewind), .done(done), .retry_fail(retry_fail),
        .rp_data(rp_data), .rp_cnt(rp_cnt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic count_to_start(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!tx_start && n < 3000);
    endtask

    task automatic send_bytes(input logic [7:0] base, input int cnt);
        for (int i = 0; i < cnt; i++) begin
            tx_byte_vld = 1'b1;
            tx_byte = base + 8'(i);
            step();
        end
        tx_byte_vld = 1'b0;
    endtask

    task automatic finish_frame();
        tx_last = 1'b1;
        step();
        tx_last = 1'b0;
        check(done && !tx_en && !retry_fail, "R8 clean finish", {done, tx_en, retry_fail}, 3'b100);
        step();
        check(!done, "R8 done single cycle", done, 0);
    endtask

    task automatic collide_through_jam();
        col = 1'b1;
        step();
        col = 1'b0;
        while (jam_on) step();
    endtask

    task automatic t_reset();
        check({tx_start, tx_en, jam_on, tx_abort, rewind, done, retry_fail} == 7'd0,
              "R12 reset outputs", {tx_start, tx_en, jam_on, tx_abort, rewind, done, retry_fail}, 0);
        check(rp_cnt == 0, "R12 reset rp_cnt", rp_cnt, 0);
    endtask

    task automatic t_basic();
        int n;
        frame_pending = 1'b1;
        count_to_start(n);
        frame_pending = 1'b0;
        check(n == 97, "R1 start delay from pending", n, 97);
        send_bytes(8'h10, 10);
        check(rp_cnt == 8, "R10 head store saturates", rp_cnt, 8);
        for (int i = 0; i < 8; i++) begin
            rp_idx = 3'(i);
            #1;
            check(rp_data == 8'h10 + 8'(i), "R10 head byte", rp_data, 8'h10 + i);
        end
        finish_frame();
    endtask

    task automatic t_carrier_restart();
        int n;
        crs = 1'b1;
        frame_pending = 1'b1;
        repeat (10) step();
        frame_pending = 1'b0;
        crs = 1'b0;
        repeat (30) step();
        crs = 1'b1;
        step();
        crs = 1'b0;
        count_to_start(n);
        check(n == 96, "R2 carrier restarts quiet count", n, 96);
        finish_frame();
    endtask

    task automatic t_gap_ignores();
        int n;
        int m;
        crs = 1'b1;
        frame_pending = 1'b1;
        repeat (5) step();
        frame_pending = 1'b0;
        crs = 1'b0;
        n = 0;
        repeat (70) begin step(); n++; end
        crs = 1'b1;
        repeat (5) begin step(); n++; end
        crs = 1'b0;
        count_to_start(m);
        check(n + m == 96, "R3 carrier in gap ignored", n + m, 96);
        finish_frame();
    endtask

    task automatic t_tick_gate();
        int n;
        bit seen;
        seen = 1'b0;
        bit_tick = 1'b0;
        frame_pending = 1'b1;
        repeat (200) begin
            step();
            if (tx_start || tx_en) seen = 1'b1;
        end
        check(!seen, "R4 no progress without tick", seen, 0);
        frame_pending = 1'b0;
        bit_tick = 1'b1;
        count_to_start(n);
        check(n == 96, "R4 delay counts ticks only", n, 96);
        finish_frame();
    endtask

    task automatic t_collide_retry();
        int n;
        int j;
        int k;
        retry_limit = 4'd3;
        frame_pending = 1'b1;
        count_to_start(n);
        frame_pending = 1'b0;
        send_bytes(8'hA0, 4);
        col = 1'b1;
        step();
        col = 1'b0;
        check(tx_abort && jam_on && tx_en, "R5 abort and jam after collision",
              {tx_abort, jam_on, tx_en}, 3'b111);
        j = 1;
        forever begin
            step();
            if (jam_on) j++;
            else break;
        end
        check(j == 32, "R5 jam length", j, 32);
        check(rewind && !tx_en && !done, "R6 rewind after jam", {rewind, tx_en, done}, 3'b100);
        n = 0;
        do begin
            col = (n == 40);
            step();
            n++;
            if (n == 41) check(!tx_abort, "R11 collision outside tx ignored", tx_abort, 0);
        end while (!tx_start && n < 3000);
        col = 1'b0;
        k = (n - 97) / SLOT;
        check(n >= 97 && ((n - 97) % SLOT) == 0 && k < 2, "R6 backoff delay after 1st collision", n, 97);
        send_bytes(8'hB0, 6);
        check(rp_cnt == 4, "R10 retry bytes not stored", rp_cnt, 4);
        for (int i = 0; i < 4; i++) begin
            rp_idx = 3'(i);
            #1;
            check(rp_data == 8'hA0 + 8'(i), "R10 head kept across retry", rp_data, 8'hA0 + i);
        end
        finish_frame();
    endtask

    task automatic t_giveup();
        int n;
        retry_limit = 4'd1;
        frame_pending = 1'b1;
        count_to_start(n);
        frame_pending = 1'b0;
        send_bytes(8'h55, 2);
        collide_through_jam();
        check(rewind && !done, "R6 first collision retried", {rewind, done}, 2'b10);
        count_to_start(n);
        collide_through_jam();
        check(done && retry_fail && !rewind, "R7 limit exceeded drops frame",
              {done, retry_fail, rewind}, 3'b110);
        repeat (20) step();
        check(retry_fail && !done && !tx_en, "R7 fail flag held", {retry_fail, done, tx_en}, 3'b100);
        frame_pending = 1'b1;
        step();
        frame_pending = 1'b0;
        check(!retry_fail, "R7 fail cleared on new frame", retry_fail, 0);
        check(rp_cnt == 0, "R10 store cleared on new frame", rp_cnt, 0);
        count_to_start(n);
        check(n == 96, "R1 delay after accept", n, 96);
        finish_frame();
    endtask

    task automatic t_same_cycle();
        int n;
        retry_limit = 4'd0;
        frame_pending = 1'b1;
        count_to_start(n);
        frame_pending = 1'b0;
        col = 1'b1;
        tx_last = 1'b1;
        step();
        col = 1'b0;
        tx_last = 1'b0;
        check(tx_abort && jam_on && !done, "R9 collision beats end of frame",
              {tx_abort, jam_on, done}, 3'b110);
        while (jam_on) step();
        check(done && retry_fail && !rewind, "R7 limit zero drops on first collision",
              {done, retry_fail, rewind}, 3'b110);
        step();
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_basic();
        t_carrier_restart();
        t_gap_ignores();
        t_tick_gate();
        t_collide_retry();
        t_giveup();
        t_same_cycle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule